// File: doc/BRIEF.md
# Stepped Instruction ALU With Result Store

The block runs a short fixed program of instruction words held in an on-chip ROM, one word for each step pulse. Each word holds two unsigned operands, an operation code, a direction bit and a result-store address. A write word sends the chosen arithmetic result (sum, difference, product or three-way compare) into a 256-word result store. A read word fetches a stored word and presents it on the output one clock later, with a one-cycle valid strobe. Once the last ROM entry has run, the block raises a finished flag and ignores further steps until reset.

The step input sets the pace. On a board it would come from a slow tick, and in simulation it is a pulse. The program image is a parameter, so each instance carries its own program.

Top module: `seq_alu_top`

## Requirements
- R1: Each ROM word is 19 bits, read from bit 18 down: operand A in [18:15], operand B in [14:11], operation code in [10:9], direction bit in [8], store address in [7:0]. ROM entry k sits at bits [19k+18:19k] of the program image parameter.
- R2: Operation code 00 yields A+B, zero-extended to 8 bits.
- R3: Operation code 01 yields A-B as an 8-bit two's complement value (for example 0-15 gives 8'hF1).
- R4: Operation code 10 yields the unsigned product A*B in 8 bits (15*15 gives 8'hE1).
- R5: Operation code 11 yields a compare code: 8'h01 when A>B, 8'h00 when A==B, 8'hFF when A<B (unsigned).
- R6: With direction bit 1, a step stores the result at the word's address and leaves the output data and valid strobe unchanged. A later write to the same address replaces the earlier word.
- R7: With direction bit 0, a step makes the output data equal to the stored word at the address on the next clock, and the valid strobe high for that one clock. The operand and operation fields have no effect.
- R8: Each clock with step high, while not finished, executes exactly one ROM entry, in ascending order from entry 0. Clocks without step change nothing at the outputs.
- R9: The step that executes the last entry sets the finished flag. The flag stays set, and later steps cause no read, no write and no output change.
- R10: Reset clears the program position, the finished flag, the output data and the valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Execute the current ROM entry on this clock |
| rd_data_o | output | 8 | Last word fetched by a read instruction |
| rd_valid_o | output | 1 | One-cycle strobe marking a fresh read word |
| done_o | output | 1 | Set after the last ROM entry has executed |

## Verification
The stored value can only be seen through a later read instruction in the same program. The hardest things to reach are therefore an overwrite of an address that has already been written, and the boundary operands, each confirmed by a read. The bench builds its own program image with entries at address 0 and 255, extreme operands, a rewrite of address 0 followed by a read, and reads whose operand fields hold junk. It runs the first part with spaced single pulses and the rest with step held high across the end of the program, so steps arrive back to back and after the finish.

// File: rtl/seq_alu_pkg.sv
package seq_alu_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_SUB = 2'b01,
      OP_MUL = 2'b10,
      OP_CMP = 2'b11
   } alu_op_e;

   localparam int OPC_W  = 2;
   localparam int DIR_W  = 1;

   // Compare codes for a result of width w
   function automatic logic [63:0] cmp_code(input int gt, input int eq);
      if (gt != 0)      return 64'd1;
      else if (eq != 0) return 64'd0;
      else              return '1;
   endfunction

endpackage

// File: rtl/sqa_pc_ctrl.sv
module sqa_pc_ctrl #(
   parameter int PROG_DEPTH = 8,
   localparam int PCW = (PROG_DEPTH > 1) ? $clog2(PROG_DEPTH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           step_i,
   output logic [PCW-1:0] pc_o,
   output logic           fire_o,
   output logic           done_o
);

   localparam logic [PCW-1:0] LAST_PC = PCW'(PROG_DEPTH - 1);

   logic [PCW-1:0] pc_q;
   logic           done_q;

   assign fire_o = step_i & ~done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         done_q <= 1'b0;
      end else if (fire_o) begin
         if (pc_q == LAST_PC) begin
            done_q <= 1'b1;
         end else begin
            pc_q <= pc_q + PCW'(1);
         end
      end
   end

   assign pc_o   = pc_q;
   assign done_o = done_q;

endmodule

// File: rtl/sqa_alu.sv
module sqa_alu
   import seq_alu_pkg::*;
#(
   parameter int OPW      = 4,
   parameter int MUL_IMPL = 0,
   localparam int RESW    = 2 * OPW
) (
   input  logic [OPW-1:0]  a_i,
   input  logic [OPW-1:0]  b_i,
   input  alu_op_e         op_i,
   output logic [RESW-1:0] res_o
);

   logic [RESW-1:0] a_ext;
   logic [RESW-1:0] b_ext;
   logic [RESW-1:0] prod;
   logic [RESW-1:0] cmp_res;

   assign a_ext = RESW'(a_i);
   assign b_ext = RESW'(b_i);

   generate
      if (MUL_IMPL == 0) begin : g_mul_op
         assign prod = a_ext * b_ext;
      end else begin : g_mul_shift_add
         logic [RESW-1:0] acc [OPW+1];
         assign acc[0] = '0;
         for (genvar gi = 0; gi < OPW; gi++) begin : g_pp
            logic [RESW-1:0] pp;
            assign pp          = b_i[gi] ? (a_ext << gi) : '0;
            assign acc[gi + 1] = acc[gi] + pp;
         end
         assign prod = acc[OPW];
      end
   endgenerate

   always_comb begin
      if (a_i > b_i)       cmp_res = RESW'(1);
      else if (a_i == b_i) cmp_res = '0;
      else                 cmp_res = '1;
   end

   always_comb begin
      unique case (op_i)
         OP_ADD:  res_o = a_ext + b_ext;
         OP_SUB:  res_o = a_ext - b_ext;
         OP_MUL:  res_o = prod;
         default: res_o = cmp_res;
      endcase
   end

endmodule

// File: rtl/sqa_res_ram.sv
module sqa_res_ram #(
   parameter int DW = 8,
   parameter int AW = 8,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic          re_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o,
   output logic          rvalid_o
);

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) begin
         store[addr_i] <= wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o  <= '0;
         rvalid_o <= 1'b0;
      end else begin
         rvalid_o <= re_i;
         if (re_i) begin
            rdata_o <= store[addr_i];
         end
      end
   end

endmodule

// File: rtl/seq_alu_top.sv
module seq_alu_top
   import seq_alu_pkg::*;
#(
   parameter int OPW        = 4,
   parameter int ADDRW      = 8,
   parameter int PROG_DEPTH = 8,
   parameter int MUL_IMPL   = 0,
   localparam int IW        = 2 * OPW + OPC_W + DIR_W + ADDRW,
   localparam int RESW      = 2 * OPW,
   parameter logic [PROG_DEPTH*IW-1:0] PROG_IMAGE = {
      19'b0000_0000_00_0_00000100,
      19'b0000_0000_00_0_00000011,
      19'b0000_0000_00_0_00000010,
      19'b0000_0000_00_0_00000001,
      19'b0111_0010_00_1_00000100,
      19'b0111_0010_11_1_00000011,
      19'b0111_0010_10_1_00000010,
      19'b0111_0010_01_1_00000001
   }
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step_i,
   output logic [RESW-1:0] rd_data_o,
   output logic            rd_valid_o,
   output logic            done_o
);

   localparam int PCW     = (PROG_DEPTH > 1) ? $clog2(PROG_DEPTH) : 1;
   localparam int ADDR_LO = 0;
   localparam int DIR_BIT = ADDRW;
   localparam int OPC_LO  = ADDRW + DIR_W;
   localparam int B_LO    = OPC_LO + OPC_W;
   localparam int A_LO    = B_LO + OPW;

   generate
      if (PROG_DEPTH < 8) begin : g_chk_depth
         $error("seq_alu_top: PROG_DEPTH must be at least 8");
      end
      if (OPW < 2 || OPW > 16) begin : g_chk_opw
         $error("seq_alu_top: OPW out of range 2..16");
      end
      if (ADDRW < 1 || ADDRW > 12) begin : g_chk_addrw
         $error("seq_alu_top: ADDRW out of range 1..12");
      end
      if (MUL_IMPL != 0 && MUL_IMPL != 1) begin : g_chk_mul
         $error("seq_alu_top: MUL_IMPL must be 0 or 1");
      end
   endgenerate

   logic [PCW-1:0]   pc;
   logic             fire;
   logic [IW-1:0]    instr;
   logic [OPW-1:0]   opa;
   logic [OPW-1:0]   opb;
   alu_op_e          op;
   logic             dir_wr;
   logic [ADDRW-1:0] addr;
   logic [RESW-1:0]  alu_res;

   sqa_pc_ctrl #(
      .PROG_DEPTH(PROG_DEPTH)
   ) u_pc (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step_i),
      .pc_o   (pc),
      .fire_o (fire),
      .done_o (done_o)
   );

   // program ROM lookup
   always_comb begin
      instr = '0;
      for (int k = 0; k < PROG_DEPTH; k++) begin
         if (pc == PCW'(k)) begin
            instr = PROG_IMAGE[k*IW +: IW];
         end
      end
   end

   assign opa    = instr[A_LO +: OPW];
   assign opb    = instr[B_LO +: OPW];
   assign op     = alu_op_e'(instr[OPC_LO +: OPC_W]);
   assign dir_wr = instr[DIR_BIT];
   assign addr   = instr[ADDR_LO +: ADDRW];

   sqa_alu #(
      .OPW      (OPW),
      .MUL_IMPL (MUL_IMPL)
   ) u_alu (
      .a_i   (opa),
      .b_i   (opb),
      .op_i  (op),
      .res_o (alu_res)
   );

   sqa_res_ram #(
      .DW (RESW),
      .AW (ADDRW)
   ) u_ram (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (fire & dir_wr),
      .re_i     (fire & ~dir_wr),
      .addr_i   (addr),
      .wdata_i  (alu_res),
      .rdata_o  (rd_data_o),
      .rvalid_o (rd_valid_o)
   );

endmodule

// File: rtl/seq_alu_checker.sv
module seq_alu_checker
   import seq_alu_pkg::*;
#(
   parameter int PCW        = 3,
   parameter int PROG_DEPTH = 8,
   parameter int RESW       = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            step_i,
   input logic            fire,
   input logic [PCW-1:0]  pc,
   input alu_op_e         op,
   input logic [RESW-1:0] alu_res,
   input logic [RESW-1:0] rd_data_o,
   input logic            rd_valid_o,
   input logic            done_o
);

   localparam logic [PCW-1:0] LAST_PC = PCW'(PROG_DEPTH - 1);

   AST_VALID_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> $past(fire)); // R7

   AST_QUIET_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> ($stable(rd_data_o) && !rd_valid_o)); // R8

   AST_PC_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && pc != LAST_PC) |=> (pc == $past(pc) + PCW'(1))); // R8

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (done_o && $stable(pc) && !rd_valid_o)); // R9

   AST_DONE_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> (pc == LAST_PC && $past(step_i))); // R9

   AST_CMP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CMP) |-> (alu_res == RESW'(0) || alu_res == RESW'(1) || alu_res == '1)); // R5

endmodule

bind seq_alu_top seq_alu_checker #(
   .PCW        (PCW),
   .PROG_DEPTH (PROG_DEPTH),
   .RESW       (RESW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .step_i     (step_i),
   .fire       (fire),
   .pc         (pc),
   .op         (op),
   .alu_res    (alu_res),
   .rd_data_o  (rd_data_o),
   .rd_valid_o (rd_valid_o),
   .done_o     (done_o)
);

// File: tb/seq_alu_top_tb.sv
module seq_alu_top_tb;

   localparam int DEPTH = 16;
   localparam int IW    = 19;

   function automatic logic [IW-1:0] mk(input int a, input int b, input int s,
                                        input int rw, input int ad);
      return {4'(a), 4'(b), 2'(s), 1'(rw), 8'(ad)};
   endfunction

   localparam logic [DEPTH*IW-1:0] IMG = {
      mk(9, 9, 2, 0, 8'h80),   // 15 read 0x80 -> 00
      mk(0, 9, 2, 1, 8'h80),   // 14 write 0*9
      mk(15, 15, 2, 0, 8'h00), // 13 read 0x00 (junk operands) -> 0F
      mk(15, 0, 1, 1, 8'h00),  // 12 overwrite 0x00 with 15-0
      mk(1, 2, 3, 0, 8'h12),   // 11 read -> 00
      mk(4, 4, 1, 0, 8'h11),   // 10 read -> 01
      mk(0, 0, 0, 0, 8'h10),   //  9 read -> FF
      mk(3, 3, 3, 0, 8'h80),   //  8 read -> E1
      mk(6, 1, 2, 0, 8'hFF),   //  7 read -> F1
      mk(5, 10, 1, 0, 8'h00),  //  6 read -> 1E
      mk(7, 7, 3, 1, 8'h12),   //  5 cmp equal
      mk(9, 3, 3, 1, 8'h11),   //  4 cmp greater
      mk(3, 9, 3, 1, 8'h10),   //  3 cmp less
      mk(15, 15, 2, 1, 8'h80), //  2 15*15
      mk(0, 15, 1, 1, 8'hFF),  //  1 0-15
      mk(15, 15, 0, 1, 8'h00)  //  0 15+15
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step = 1'b0;
   logic [7:0] rd_data;
   logic       rd_valid;
   logic       done;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   seq_alu_top #(
      .PROG_DEPTH (DEPTH),
      .MUL_IMPL   (1),
      .PROG_IMAGE (IMG)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_i     (step),
      .rd_data_o  (rd_data),
      .rd_valid_o (rd_valid),
      .done_o     (done)
   );

   // behavioural reference
   int    m_mem [256];
   int    m_pc = 0;
   bit    m_done = 1'b0;
   int    m_data = 0;
   bit    m_valid = 1'b0;
   string m_tag = "R8";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pc = 0; m_done = 0; m_data = 0; m_valid = 0; m_tag = "R10";
      end else begin
         m_valid = 0;
         if (step && !m_done) begin
            logic [IW-1:0] w;
            int a, b, s, ad, r;
            w  = IMG[m_pc*IW +: IW];
            a  = int'(w[18:15]); b = int'(w[14:11]);
            s  = int'(w[10:9]);  ad = int'(w[7:0]);
            case (s)
               0: r = a + b;
               1: r = (a - b) & 255;
               2: r = a * b;
               default: r = (a > b) ? 1 : ((a == b) ? 0 : 255);
            endcase
            if (w[8]) begin
               m_mem[ad] = r; m_tag = "R6";
            end else begin
               m_data = m_mem[ad]; m_valid = 1; m_tag = "R7";
            end
            if (m_pc == DEPTH - 1) m_done = 1; else m_pc++;
         end else begin
            m_tag = m_done ? "R9" : "R8";
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-clock comparison against the model
   bit cmp_en = 1'b0;
   always @(negedge clk) begin
      if (cmp_en && rst_n) begin
         check({m_tag, " data"}, int'(rd_data), m_data);
         check({m_tag, " valid"}, int'(rd_valid), int'(m_valid));
         check("R9 done", int'(done), int'(m_done));
      end
   end

   // hand-computed read results, in read order
   int    hand_idx = 0;
   int    hand_val [8] = '{8'h1E, 8'hF1, 8'hE1, 8'hFF, 8'h01, 8'h00, 8'h0F, 8'h00};
   string hand_req [8] = '{"R1 R2", "R3", "R4", "R5 gt<", "R5 gt", "R5 eq",
                           "R6 overwrite R3", "R7 R4 zero"};
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (hand_idx < 8) check(hand_req[hand_idx], int'(rd_data), hand_val[hand_idx]);
         hand_idx++;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   bit finished = 1'b0;

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      check("R10 data", int'(rd_data), 0);
      check("R10 valid", int'(rd_valid), 0);
      check("R10 done", int'(done), 0);
      cmp_en = 1'b1;
      // spaced single pulses: entries 0..9
      for (int i = 0; i < 10; i++) begin
         step = 1'b1; tick(1);
         step = 1'b0; tick(2);
      end
      // step held high: entries 10..15 and four more after the end
      step = 1'b1; tick(10);
      step = 1'b0; tick(3);
      check("R9 done held", int'(done), 1);
      check("R7 read count", hand_idx, 8);
      check("R9 last data kept", int'(rd_data), 0);
      // reset again and run the first entry (a write)
      cmp_en = 1'b0;
      rst_n = 1'b0; tick(2);
      rst_n = 1'b1; tick(1);
      check("R10 done cleared", int'(done), 0);
      check("R10 data cleared", int'(rd_data), 0);
      cmp_en = 1'b1;
      step = 1'b1; tick(1);
      step = 1'b0; tick(1);
      check("R6 no strobe on write", int'(rd_valid), 0);
      tick(2);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule